// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block holds the four control registers that a small in-order core needs for exception handling: the exception PC, the trap cause, a scratch word for the handler's context pointer, and a status word. Instructions access these registers through a single-cycle port. That port can read a register, swap a new value in while returning the old one, set bits, or clear bits. The read data always reflects the register contents before the access.

When the pipeline raises a trap, the unit captures the faulting PC and a cause code, such as 8 for a system call or 2 for an illegal instruction. It then pushes a four-deep stack of privilege and interrupt-enable entries that lives in the low twelve bits of the status word, and issues a one-cycle fetch redirect to a fixed entry address chosen by the mode the trap came from. An exception return pops that stack and redirects fetch to whatever the exception PC holds at that moment. Software has usually rewritten it by then, for example to step past a system call.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset, the exception PC, cause and scratch registers read 0, the status register reads 0x24E (entry 0 = machine privilege with enable 0, entries 1 to 3 = user privilege with enable 1), and redirect_valid is 0.
- R2: With csr_en high, csr_rdata shows, in the same cycle, the pre-access value of the register chosen by csr_sel (0 exception PC, 1 cause, 2 scratch, 3 status). Op 0 (read) changes no register.
- R3: Op 1 (swap) returns the old value on csr_rdata and writes csr_wdata into the selected register. The new value is visible from the next cycle.
- R4: Op 2 ORs csr_wdata into the selected register. Op 3 clears the bits that are set in csr_wdata.
- R5: A trap loads the exception PC with trap_pc and the cause register with trap_cause, zero-extended.
- R6: Status entry k occupies bits 3k+2:3k, with the enable bit at 3k and the privilege field at 3k+2:3k+1 (0 user, 3 machine). A trap moves entry k to entry k+1 for k of 1 and 2, and drops the old entry 3. The new entry 1 is {trap_mode, old entry 0 enable bit}, and entry 0 becomes machine privilege with enable 0. Bits 31:12 are unchanged.
- R7: In the cycle after a trap, redirect_valid is 1 and redirect_pc is 0x100 + 0x40 × trap_mode, which gives 0x100 for a trap from user mode.
- R8: An exception return moves entry k+1 down to entry k and refills entry 3 with user privilege and enable 1. In the next cycle it redirects to the exception PC value held at the time of the return, including any value software wrote there.
- R9: A CSR write or modify in the same cycle as a trap or a return is discarded in every register, while csr_rdata still returns the old value.
- R10: When a trap and a return arrive together, the trap is taken and the return is ignored.
- R11: redirect_valid is high for exactly one cycle per accepted trap or return, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_en | input | 1 | CSR access this cycle |
| csr_op | input | 2 | 0 read, 1 swap, 2 set bits, 3 clear bits |
| csr_sel | input | 2 | 0 exception PC, 1 cause, 2 scratch, 3 status |
| csr_wdata | input | XLEN | Operand for swap, set or clear |
| csr_rdata | output | XLEN | Pre-access value of the selected register |
| trap_valid | input | 1 | Take a trap this cycle |
| trap_cause | input | CAUSE_W | Cause code of the trap |
| trap_pc | input | XLEN | Address of the faulting instruction |
| trap_mode | input | 2 | Privilege mode the trap was raised from |
| eret_valid | input | 1 | Return from handler this cycle |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | XLEN | Fetch redirect target |

## Verification
A corrupted privilege stack has no immediate visible effect. It shows only when software reads the status register or when a later trap or return shifts the damaged entry into place. For that reason the bench reads every register back after each trap and return, and runs several nested traps and returns so that every stack level moves at least once. A stale exception PC or a wrong mode decode appears on redirect_pc one cycle after the request. A missed write-suppression appears on the next read of the register concerned.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

    typedef enum logic [1:0] {
        CSR_SEL_EPC     = 2'd0,
        CSR_SEL_CAUSE   = 2'd1,
        CSR_SEL_SCRATCH = 2'd2,
        CSR_SEL_STATUS  = 2'd3
    } csr_sel_e;

    typedef enum logic [1:0] {
        CSR_OP_READ  = 2'd0,
        CSR_OP_SWAP  = 2'd1,
        CSR_OP_SET   = 2'd2,
        CSR_OP_CLEAR = 2'd3
    } csr_op_e;

    localparam int          ENTRY_W  = 3;
    localparam int          PRV_W    = 2;
    localparam logic [1:0]  PRV_USER = 2'd0;
    localparam logic [1:0]  PRV_MACH = 2'd3;

endpackage

// File: rtl/tcu_csr_alu.sv
module tcu_csr_alu
    import trap_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] new_val,
    output logic            writes
);

    always_comb begin
        new_val = old_val;
        writes  = 1'b1;
        case (csr_op_e'(op))
            CSR_OP_READ:  writes  = 1'b0;
            CSR_OP_SWAP:  new_val = operand;
            CSR_OP_SET:   new_val = old_val | operand;
            CSR_OP_CLEAR: new_val = old_val & ~operand;
            default:      writes  = 1'b0;
        endcase
    end

endmodule

// File: rtl/tcu_stack_shift.sv
module tcu_stack_shift
    import trap_csr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LEVELS = 4
) (
    input  logic [XLEN-1:0] stat_in,
    input  logic            push,
    input  logic            pop,
    input  logic [1:0]      from_mode,
    output logic [XLEN-1:0] stat_out
);

    localparam int STK_W = LEVELS * ENTRY_W;

    logic [STK_W-1:0] pushed;
    logic [STK_W-1:0] popped;

    // Each level picks its neighbour below (push) or above (pop).
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        if (g == 0) begin : g_bottom_push
            assign pushed[g*ENTRY_W +: ENTRY_W] = {PRV_MACH, 1'b0};
        end else if (g == 1) begin : g_mode_push
            assign pushed[g*ENTRY_W +: ENTRY_W] = {from_mode, stat_in[0]};
        end else begin : g_shift_push
            assign pushed[g*ENTRY_W +: ENTRY_W] = stat_in[(g-1)*ENTRY_W +: ENTRY_W];
        end

        if (g == LEVELS - 1) begin : g_top_pop
            assign popped[g*ENTRY_W +: ENTRY_W] = {PRV_USER, 1'b1};
        end else begin : g_shift_pop
            assign popped[g*ENTRY_W +: ENTRY_W] = stat_in[(g+1)*ENTRY_W +: ENTRY_W];
        end
    end

    always_comb begin
        stat_out = stat_in;
        if (push) begin
            stat_out[STK_W-1:0] = pushed;
        end else if (pop) begin
            stat_out[STK_W-1:0] = popped;
        end
    end

endmodule

// File: rtl/tcu_vector_gen.sv
module tcu_vector_gen #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'h0000_0100,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0040
) (
    input  logic [1:0]      mode,
    output logic [XLEN-1:0] entry_pc
);

    logic [XLEN-1:0] mode_ext;

    assign mode_ext = {{(XLEN-2){1'b0}}, mode};
    assign entry_pc = VEC_BASE + VEC_STRIDE * mode_ext;

endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
    import trap_csr_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              LEVELS     = 4,
    parameter int              CAUSE_W    = 4,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'h0000_0100,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_en,
    input  logic [1:0]         csr_op,
    input  logic [1:0]         csr_sel,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic               trap_valid,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [1:0]         trap_mode,
    input  logic               eret_valid,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc
);

    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] scratch;
        logic [XLEN-1:0] status;
        logic            redir_vld;
        logic [XLEN-1:0] redir_pc;
    } unit_state_t;

    function automatic logic [XLEN-1:0] status_at_reset();
        logic [XLEN-1:0] v;
        v = '0;
        for (int i = 0; i < LEVELS; i++) begin
            v[i*ENTRY_W +: ENTRY_W] = (i == 0) ? {PRV_MACH, 1'b0} : {PRV_USER, 1'b1};
        end
        return v;
    endfunction

    localparam logic [XLEN-1:0] STATUS_RST = status_at_reset();

    unit_state_t     st_d, st_q;
    logic [XLEN-1:0] sel_old;
    logic [XLEN-1:0] alu_val;
    logic            alu_writes;
    logic [XLEN-1:0] stack_next;
    logic [XLEN-1:0] vec_pc;
    logic            take_trap;
    logic            take_eret;

    assign take_trap = trap_valid;
    assign take_eret = eret_valid & ~trap_valid;

    always_comb begin
        case (csr_sel_e'(csr_sel))
            CSR_SEL_EPC:     sel_old = st_q.epc;
            CSR_SEL_CAUSE:   sel_old = st_q.cause;
            CSR_SEL_SCRATCH: sel_old = st_q.scratch;
            default:         sel_old = st_q.status;
        endcase
    end

    tcu_csr_alu #(.XLEN(XLEN)) i_alu (
        .op      (csr_op),
        .old_val (sel_old),
        .operand (csr_wdata),
        .new_val (alu_val),
        .writes  (alu_writes)
    );

    tcu_stack_shift #(.XLEN(XLEN), .LEVELS(LEVELS)) i_stack (
        .stat_in   (st_q.status),
        .push      (take_trap),
        .pop       (take_eret),
        .from_mode (trap_mode),
        .stat_out  (stack_next)
    );

    tcu_vector_gen #(
        .XLEN(XLEN), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) i_vec (
        .mode     (trap_mode),
        .entry_pc (vec_pc)
    );

    always_comb begin
        st_d           = st_q;
        st_d.redir_vld = 1'b0;

        // Instruction writes only when no trap or return claims the cycle.
        if (csr_en && alu_writes && !trap_valid && !eret_valid) begin
            case (csr_sel_e'(csr_sel))
                CSR_SEL_EPC:     st_d.epc     = alu_val;
                CSR_SEL_CAUSE:   st_d.cause   = alu_val;
                CSR_SEL_SCRATCH: st_d.scratch = alu_val;
                default:         st_d.status  = alu_val;
            endcase
        end

        if (take_trap) begin
            st_d.epc       = trap_pc;
            st_d.cause     = {{(XLEN-CAUSE_W){1'b0}}, trap_cause};
            st_d.status    = stack_next;
            st_d.redir_vld = 1'b1;
            st_d.redir_pc  = vec_pc;
        end else if (take_eret) begin
            st_d.status    = stack_next;
            st_d.redir_vld = 1'b1;
            st_d.redir_pc  = st_q.epc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.epc       <= '0;
            st_q.cause     <= '0;
            st_q.scratch   <= '0;
            st_q.status    <= STATUS_RST;
            st_q.redir_vld <= 1'b0;
            st_q.redir_pc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_rdata      = csr_en ? sel_old : '0;
    assign redirect_valid = st_q.redir_vld;
    assign redirect_pc    = st_q.redir_pc;

endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
    parameter int              XLEN       = 32,
    parameter int              LEVELS     = 4,
    parameter int              CAUSE_W    = 4,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'h0000_0100,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0040
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_en,
    input logic [1:0]         csr_op,
    input logic               trap_valid,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [XLEN-1:0]    trap_pc,
    input logic [1:0]         trap_mode,
    input logic               eret_valid,
    input logic               redirect_valid,
    input logic [XLEN-1:0]    redirect_pc,
    input logic [XLEN-1:0]    epc,
    input logic [XLEN-1:0]    cause,
    input logic [XLEN-1:0]    scratch,
    input logic [XLEN-1:0]    status
);

    localparam int STK_W = LEVELS * 3;

    function automatic logic [XLEN-1:0] entry_of(logic [1:0] m);
        return VEC_BASE + VEC_STRIDE * {{(XLEN-2){1'b0}}, m};
    endfunction

    assert_trap_records_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (epc == $past(trap_pc)) &&
                       (cause == {{(XLEN-CAUSE_W){1'b0}}, $past(trap_cause)}));

    assert_trap_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (status[2:0] == 3'b110) &&
                       (status[5:3] == {$past(trap_mode), $past(status[0])}) &&
                       (status[STK_W-1:6] == $past(status[STK_W-4:3])) &&
                       (status[XLEN-1:STK_W] == $past(status[XLEN-1:STK_W])));

    assert_trap_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> redirect_valid && (redirect_pc == entry_of($past(trap_mode))));

    assert_eret_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_valid && !trap_valid) |=> redirect_valid &&
            (redirect_pc == $past(epc)) &&
            (status[STK_W-1:STK_W-3] == 3'b001) &&
            (status[STK_W-4:0] == $past(status[STK_W-1:3])));

    assert_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && (trap_valid || eret_valid)) |=> $stable(scratch));

    assert_read_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_op == 2'd0 && !trap_valid && !eret_valid) |=>
            $stable(epc) && $stable(cause) && $stable(scratch) && $stable(status));

    assert_redirect_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(trap_valid || eret_valid));

endmodule

bind trap_csr_unit tcu_checker #(
    .XLEN(XLEN), .LEVELS(LEVELS), .CAUSE_W(CAUSE_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) i_tcu_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .csr_en         (csr_en),
    .csr_op         (csr_op),
    .trap_valid     (trap_valid),
    .trap_cause     (trap_cause),
    .trap_pc        (trap_pc),
    .trap_mode      (trap_mode),
    .eret_valid     (eret_valid),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .epc            (st_q.epc),
    .cause          (st_q.cause),
    .scratch        (st_q.scratch),
    .status         (st_q.status)
);

// File: tb/test_trap_csr_unit.sv
module test_trap_csr_unit;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            csr_en;
    logic [1:0]      csr_op;
    logic [1:0]      csr_sel;
    logic [XLEN-1:0] csr_wdata;
    logic [XLEN-1:0] csr_rdata;
    logic            trap_valid;
    logic [3:0]      trap_cause;
    logic [XLEN-1:0] trap_pc;
    logic [1:0]      trap_mode;
    logic            eret_valid;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;

    always #5 clk = ~clk;

    trap_csr_unit i_trap_csr_unit (
        .clk(clk), .rst_n(rst_n),
        .csr_en(csr_en), .csr_op(csr_op), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .trap_mode(trap_mode),
        .eret_valid(eret_valid),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    int              total = 0;
    int              bad   = 0;
    bit              finished = 1'b0;
    logic [XLEN-1:0] exp_q[$];
    logic [XLEN-1:0] m_reg[4];   // 0 epc, 1 cause, 2 scratch, 3 status

    task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] pushed(logic [XLEN-1:0] s, logic [1:0] m);
        return {s[31:12], s[8:3], m, s[0], 3'b110};
    endfunction

    function automatic logic [XLEN-1:0] popped(logic [XLEN-1:0] s);
        return {s[31:12], 3'b001, s[11:3]};
    endfunction

    function automatic logic [XLEN-1:0] apply_op(logic [1:0] op, logic [XLEN-1:0] o,
                                                 logic [XLEN-1:0] w);
        case (op)
            2'd1:    return w;
            2'd2:    return o | w;
            2'd3:    return o & ~w;
            default: return o;
        endcase
    endfunction

    task automatic idle();
        csr_en = 0; csr_op = 0; csr_sel = 0; csr_wdata = 0;
        trap_valid = 0; trap_cause = 0; trap_pc = 0; trap_mode = 0;
        eret_valid = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic csr(logic [1:0] op, logic [1:0] sel, logic [XLEN-1:0] w, string req);
        csr_en = 1; csr_op = op; csr_sel = sel; csr_wdata = w;
        #1;
        chk(req, csr_rdata, m_reg[sel]);
        m_reg[sel] = apply_op(op, m_reg[sel], w);
        step();
    endtask

    task automatic read_all(string req);
        for (int s = 0; s < 4; s++) csr(2'd0, 2'(s), '0, req);
    endtask

    task automatic trap(logic [3:0] c, logic [XLEN-1:0] pc, logic [1:0] m,
                        bit also_eret, bit also_write, logic [1:0] sel,
                        logic [XLEN-1:0] w);
        trap_valid = 1; trap_cause = c; trap_pc = pc; trap_mode = m;
        eret_valid = also_eret;
        if (also_write) begin
            csr_en = 1; csr_op = 2'd1; csr_sel = sel; csr_wdata = w;
            #1;
            chk("R9 read during trap", csr_rdata, m_reg[sel]);
        end
        exp_q.push_back(32'h100 + 32'h40 * {30'd0, m});
        m_reg[0] = pc;
        m_reg[1] = {28'd0, c};
        m_reg[3] = pushed(m_reg[3], m);
        step();
    endtask

    task automatic eret(bit also_write, logic [1:0] sel, logic [XLEN-1:0] w);
        eret_valid = 1;
        if (also_write) begin
            csr_en = 1; csr_op = 2'd1; csr_sel = sel; csr_wdata = w;
            #1;
            chk("R9 read during return", csr_rdata, m_reg[sel]);
        end
        exp_q.push_back(m_reg[0]);
        m_reg[3] = popped(m_reg[3]);
        step();
    endtask

    task automatic no_redirect(string req);
        step();
        chk(req, {31'd0, redirect_valid}, 32'd0);
    endtask

    // Monitor: every redirect must match the oldest expected target.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished && redirect_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 spurious redirect actual=%h expected=none", redirect_pc);
            end else begin
                chk("R7 R8 redirect target", redirect_pc, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        m_reg[0] = 0; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 32'h0000_024E;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state and R2 plain reads
        chk("R1 redirect idle", {31'd0, redirect_valid}, 32'd0);
        read_all("R1 R2 reset values");

        // R3 swap on scratch, twice
        csr(2'd1, 2'd2, 32'hDEAD_0000, "R3 swap returns old");
        csr(2'd1, 2'd2, 32'h1234_5678, "R3 swap returns previous write");
        // R4 set and clear on upper status bits
        csr(2'd2, 2'd3, 32'h0003_0000, "R4 set bits");
        csr(2'd3, 2'd3, 32'h0001_0000, "R4 clear bits");
        read_all("R3 R4 readback");

        // R5 R6 R7 system call from user mode
        trap(4'd8, 32'h0000_2000, 2'd0, 0, 0, 0, 0);
        no_redirect("R11 single pulse after trap");
        read_all("R5 R6 after user trap");

        // R8 software advances the saved PC, then returns
        csr(2'd1, 2'd0, 32'h0000_2004, "R8 rewrite saved pc");
        eret(0, 0, 0);
        no_redirect("R11 single pulse after return");
        read_all("R8 after return");

        // Nested traps from machine and supervisor-level modes
        trap(4'd2, 32'h0000_3000, 2'd3, 0, 0, 0, 0);
        trap(4'd5, 32'h0000_4000, 2'd1, 0, 0, 0, 0);
        read_all("R6 R7 nested traps");

        // R9 write dropped during trap and during return
        trap(4'd8, 32'h0000_5000, 2'd2, 0, 1, 2'd2, 32'hAAAA_5555);
        read_all("R9 scratch kept after trap");
        eret(1, 2'd3, 32'hFFFF_FFFF);
        read_all("R9 status kept after return");

        // R10 trap and return together: trap wins
        trap(4'd3, 32'h0000_6000, 2'd0, 1, 0, 0, 0);
        read_all("R10 trap beats return");

        // R8 repeated returns drain the stack and refill the top
        for (int i = 0; i < 5; i++) eret(0, 0, 0);
        read_all("R8 stack refill");

        step();
        step();
        chk("R11 all redirects seen", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule